// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Comparator Bank

This block watches a 32-bit soft processor for debug events. It holds a few instruction breakpoint slots and a few data watchpoint slots. A debugger or debug monitor programs the slots through a single-cycle register write port. In every cycle the block compares the fetch PC with each enabled breakpoint. It also compares the address and direction of the current data access with each watchpoint, according to that watchpoint's mode.

Any breakpoint hit raises a breakpoint exception request to the core. Any watchpoint hit raises a watchpoint exception request, unless a breakpoint hit in the same cycle. A watchpoint hit also drives a block signal, which stops the load or store before it changes memory. All match outputs are combinational, so they are valid in the same cycle as the inputs that cause them. A write to a slot changes the comparisons only from the next clock edge.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset, every breakpoint is disabled and every watchpoint is in mode 00 (off). While `rst_n` is low and until a slot is written, `bp_req`, `wp_req`, `mem_block` and both hit vectors are all zero.
- R2: Breakpoint k hits when all three of these hold: it is enabled, `fetch_valid` is 1, and `fetch_pc` equals its stored address. `bp_hit_vec[k]` shows that hit, and any such hit drives `bp_req` high in the same cycle.
- R3: A breakpoint with its enable bit cleared never hits, whatever address it holds.
- R4: The watchpoint mode is two bits: 00 off, 01 matches reads, 10 matches writes, 11 matches both. `mem_write`=1 marks a write and 0 marks a read. A hit also needs `mem_valid`=1.
- R5: A watchpoint in mode 00 never hits, whatever address is stored in it.
- R6: A watchpoint covers one byte address. An access address that differs from the stored address in any bit does not hit.
- R7: `mem_block` is 1 in the same cycle as any watchpoint hit, so the access does not complete. It is 0 when no watchpoint hits.
- R8: `wp_req` is raised only when at least one watchpoint hits. With no hit, both `wp_req` and `mem_block` stay low.
- R9: When a breakpoint and a watchpoint hit in the same cycle, only `bp_req` is raised and `wp_req` stays low.
- R10: A slot write changes the comparisons from the next rising clock edge. In the cycle of the write, the old slot contents still decide the hits.
- R11: Configuration writes use these fields:
  - `cfg_sel`=0 writes breakpoint `cfg_idx`, taking the address from `cfg_addr` and the enable bit from `cfg_ctrl[0]`.
  - `cfg_sel`=1 writes watchpoint `cfg_idx`, taking the address from `cfg_addr` and the mode from `cfg_ctrl`.
  - A write leaves every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_sel | input | 1 | 0 selects a breakpoint slot, 1 selects a watchpoint slot |
| cfg_idx | input | 2 | Slot index |
| cfg_addr | input | 32 | Address to store in the slot |
| cfg_ctrl | input | 2 | Breakpoint enable in bit 0, or the watchpoint mode |
| fetch_valid | input | 1 | A fetch PC is presented this cycle |
| fetch_pc | input | 32 | PC of the instruction about to execute |
| mem_valid | input | 1 | A data access is presented this cycle |
| mem_addr | input | 32 | Byte address of the data access |
| mem_write | input | 1 | 1 for a store, 0 for a load |
| bp_req | output | 1 | Breakpoint exception request |
| wp_req | output | 1 | Watchpoint exception request |
| mem_block | output | 1 | Stops the current data access |
| bp_hit_vec | output | 4 | Per-breakpoint hit |
| wp_hit_vec | output | 4 | Per-watchpoint hit |

## Verification
The bench builds the block with its defaults: four breakpoint slots, four watchpoint slots and 32-bit addresses. With four watchpoints, all four modes can be loaded into separate slots at the same time, so one access checks every mode against the same address. Every value of the two-bit index maps to a real slot, so a write to any index can be checked for leaving the other three slots unchanged. The full 32-bit address width lets the bench test single-bit address differences, including the top bit.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

  typedef enum logic [1:0] {
    WP_OFF = 2'b00,
    WP_RD  = 2'b01,
    WP_WR  = 2'b10,
    WP_RW  = 2'b11
  } wp_mode_e;

  // Direction qualifier: bit 0 of the mode admits reads, bit 1 admits writes.
  function automatic logic wp_dir_ok(input wp_mode_e mode, input logic is_write);
    logic [1:0] mb;
    mb = mode;
    return is_write ? mb[1] : mb[0];
  endfunction

  // The two exception requests; the breakpoint wins because it is older in the pipe.
  function automatic logic [1:0] req_resolve(input logic any_bp, input logic any_wp);
    return {any_wp & ~any_bp, any_bp};
  endfunction

endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_enable,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  output logic              hit
);

  logic [ADDR_W-1:0] addr_q;
  logic              en_q;
  logic              pc_eq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      addr_q <= wr_addr;
      en_q   <= wr_enable;
    end
  end

  assign pc_eq = (pc == addr_q);
  assign hit   = en_q & pc_valid & pc_eq;

  a_r10_bp_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (addr_q == $past(wr_addr)) && (en_q == $past(wr_enable)));

  a_r3_bp_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(wr_en) && !$past(wr_enable)) |-> !hit);

endmodule

// File: rtl/dbg_wp_slot.sv
module dbg_wp_slot
  import dbg_match_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_mode,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              hit
);

  logic [ADDR_W-1:0] addr_q;
  wp_mode_e          mode_q;
  logic              addr_eq;
  logic              dir_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= WP_OFF;
    end else if (wr_en) begin
      addr_q <= wr_addr;
      mode_q <= wp_mode_e'(wr_mode);
    end
  end

  assign addr_eq = (acc_addr == addr_q);
  assign dir_ok  = wp_dir_ok(mode_q, acc_write);
  assign hit     = acc_valid & addr_eq & dir_ok;

  a_r5_off_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(wr_en) && ($past(wr_mode) == 2'b00)) |-> !hit);

  a_r10_wp_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (addr_q == $past(wr_addr)) && (mode_q == wp_mode_e'($past(wr_mode))));

  a_r6_exact_byte: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (acc_addr == addr_q));

endmodule

// File: rtl/dbg_req_arb.sv
module dbg_req_arb
  import dbg_match_pkg::*;
#(
  parameter int N_BP = 4,
  parameter int N_WP = 4
) (
  input  logic [N_BP-1:0] bp_hits,
  input  logic [N_WP-1:0] wp_hits,
  output logic            bp_req,
  output logic            wp_req,
  output logic            mem_block
);

  logic       any_bp;
  logic       any_wp;
  logic [1:0] reqs;

  assign any_bp    = |bp_hits;
  assign any_wp    = |wp_hits;
  assign reqs      = req_resolve(any_bp, any_wp);
  assign bp_req    = reqs[0];
  assign wp_req    = reqs[1];
  assign mem_block = any_wp;

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit #(
  parameter int ADDR_W = 32,
  parameter int N_BP   = 4,
  parameter int N_WP   = 4,
  localparam int N_MAX = (N_BP > N_WP) ? N_BP : N_WP,
  localparam int IDX_W = (N_MAX > 1) ? $clog2(N_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_ctrl,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_write,
  output logic              bp_req,
  output logic              wp_req,
  output logic              mem_block,
  output logic [N_BP-1:0]   bp_hit_vec,
  output logic [N_WP-1:0]   wp_hit_vec
);

  logic [N_BP-1:0] bp_wr;
  logic [N_WP-1:0] wp_wr;

  for (genvar k = 0; k < N_BP; k++) begin : g_bp
    assign bp_wr[k] = cfg_we & ~cfg_sel & (cfg_idx == IDX_W'(k));
    dbg_bp_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bp_wr[k]), .wr_addr(cfg_addr), .wr_enable(cfg_ctrl[0]),
      .pc_valid(fetch_valid), .pc(fetch_pc), .hit(bp_hit_vec[k])
    );
  end

  for (genvar k = 0; k < N_WP; k++) begin : g_wp
    assign wp_wr[k] = cfg_we & cfg_sel & (cfg_idx == IDX_W'(k));
    dbg_wp_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wp_wr[k]), .wr_addr(cfg_addr), .wr_mode(cfg_ctrl),
      .acc_valid(mem_valid), .acc_addr(mem_addr), .acc_write(mem_write),
      .hit(wp_hit_vec[k])
    );
  end

  dbg_req_arb #(.N_BP(N_BP), .N_WP(N_WP)) u_arb (
    .bp_hits(bp_hit_vec), .wp_hits(wp_hit_vec),
    .bp_req(bp_req), .wp_req(wp_req), .mem_block(mem_block)
  );

  a_r9_bp_over_wp: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> !wp_req);

  a_r7_block_on_wp: assert property (@(posedge clk) disable iff (!rst_n)
    (|wp_hit_vec) |-> mem_block);

  a_r8_wp_req_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    wp_req |-> (|wp_hit_vec));

  a_r2_bp_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> (fetch_valid && (|bp_hit_vec)));

  a_r4_wp_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    (|wp_hit_vec) |-> mem_valid);

endmodule

// File: tb/dbg_match_unit_bench.sv
`timescale 1ns/1ps
module dbg_match_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [1:0]  cfg_idx, cfg_ctrl;
  logic [31:0] cfg_addr, fetch_pc, mem_addr;
  logic        fetch_valid, mem_valid, mem_write;
  logic        bp_req, wp_req, mem_block;
  logic [3:0]  bp_hit_vec, wp_hit_vec;

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit done = 0;

  // reference state
  int unsigned ref_bp_addr [4];
  bit          ref_bp_en   [4];
  int unsigned ref_wp_addr [4];
  int          ref_wp_mode [4];

  always #2 clk = ~clk;

  dbg_match_unit u_dbg_match_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_addr(cfg_addr), .cfg_ctrl(cfg_ctrl),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_write(mem_write),
    .bp_req(bp_req), .wp_req(wp_req), .mem_block(mem_block),
    .bp_hit_vec(bp_hit_vec), .wp_hit_vec(wp_hit_vec)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        ref_bp_addr[i] = 0; ref_bp_en[i] = 0; ref_wp_addr[i] = 0; ref_wp_mode[i] = 0;
      end
    end else if (cfg_we) begin
      if (cfg_sel == 0) begin
        ref_bp_addr[cfg_idx] = cfg_addr; ref_bp_en[cfg_idx] = cfg_ctrl[0];
      end else begin
        ref_wp_addr[cfg_idx] = cfg_addr; ref_wp_mode[cfg_idx] = int'(cfg_ctrl);
      end
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      int ebp, ewp, wants_rd, wants_wr;
      ebp = 0; ewp = 0;
      for (int i = 0; i < 4; i++) begin
        if (ref_bp_en[i] && fetch_valid && fetch_pc == ref_bp_addr[i]) ebp |= (1 << i);
        wants_rd = (ref_wp_mode[i] == 1 || ref_wp_mode[i] == 3);
        wants_wr = (ref_wp_mode[i] >= 2);
        if (mem_valid && mem_addr == ref_wp_addr[i] &&
            ((mem_write && wants_wr) || (!mem_write && wants_rd))) ewp |= (1 << i);
      end
      check("bp_hit_vec", int'(bp_hit_vec), ebp);
      check("wp_hit_vec", int'(wp_hit_vec), ewp);
      check("bp_req", int'(bp_req), int'(ebp != 0));
      check("wp_req", int'(wp_req), int'(ewp != 0 && ebp == 0));
      check("mem_block", int'(mem_block), int'(ewp != 0));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cfg(input bit sel, input int idx, input int unsigned a, input int ctrl);
    cfg_we = 1; cfg_sel = sel; cfg_idx = 2'(idx); cfg_addr = a; cfg_ctrl = 2'(ctrl);
    step();
    cfg_we = 0;
  endtask

  task automatic fetch(input int unsigned pc);
    fetch_valid = 1; fetch_pc = pc; step(); fetch_valid = 0;
  endtask

  task automatic access(input int unsigned a, input bit wr);
    mem_valid = 1; mem_addr = a; mem_write = wr; step(); mem_valid = 0;
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_idx = 0; cfg_addr = 0; cfg_ctrl = 0;
    fetch_valid = 1; fetch_pc = 0; mem_valid = 1; mem_addr = 0; mem_write = 0;
    // R1: reset values, presented addresses equal the reset address 0
    repeat (3) step();
    rst_n = 1;
    step();
    fetch_valid = 0; mem_valid = 0;

    tag = "R2";
    cfg(0, 1, 32'h0000_1000, 1);
    fetch(32'h0000_1000); fetch(32'h0000_1004);
    fetch_valid = 0; fetch_pc = 32'h0000_1000; step();

    tag = "R3";
    cfg(0, 1, 32'h0000_1000, 0);
    fetch(32'h0000_1000);
    cfg(0, 2, 32'h0000_2000, 2); // bit0 clear: stays disabled
    fetch(32'h0000_2000);

    tag = "R11";
    cfg(0, 0, 32'hA0, 1); cfg(0, 3, 32'hA0, 1); cfg(1, 2, 32'hB0, 3);
    fetch(32'hA0); access(32'hB0, 0); access(32'hB0, 1);
    cfg(0, 3, 32'hC0, 1);
    fetch(32'hA0); fetch(32'hC0);

    tag = "R4";
    for (int m = 0; m < 4; m++) cfg(1, m, 32'h8000_0040, m);
    access(32'h8000_0040, 0); access(32'h8000_0040, 1);
    mem_valid = 0; mem_addr = 32'h8000_0040; step();

    tag = "R5";
    cfg(1, 0, 32'h0, 0);
    access(32'h0, 0); access(32'h0, 1);

    tag = "R6";
    for (int b = 0; b < 32; b++) access(32'h8000_0040 ^ (32'h1 << b), b % 2);
    access(32'h8000_0041, 1);

    tag = "R7";
    access(32'h8000_0040, 1);
    tag = "R8";
    for (int m = 0; m < 4; m++) cfg(1, m, 32'h0, 0);
    access(32'h8000_0040, 1); access(32'h0, 0);

    tag = "R9";
    cfg(1, 1, 32'h300, 3);
    fetch_valid = 1; fetch_pc = 32'hA0; mem_valid = 1; mem_addr = 32'h300; mem_write = 0;
    step();
    fetch_valid = 0; mem_valid = 0;

    tag = "R10";
    cfg_we = 1; cfg_sel = 1; cfg_idx = 3; cfg_addr = 32'h400; cfg_ctrl = 2'b11;
    mem_valid = 1; mem_addr = 32'h400; mem_write = 1;
    @(negedge clk); // old contents decide: no hit this cycle
    step();
    cfg_we = 0;
    step(); // new contents: hit
    mem_valid = 0;

    tag = "R2";
    for (int n = 0; n < 400; n++) begin
      fetch_valid = $urandom_range(0, 1); fetch_pc = 32'hA0 + 32'h20 * $urandom_range(0, 2);
      mem_valid = $urandom_range(0, 1); mem_addr = 32'h300 + 32'h100 * $urandom_range(0, 1);
      mem_write = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) begin
        cfg_we = 1; cfg_sel = $urandom_range(0, 1); cfg_idx = 2'($urandom_range(0, 3));
        cfg_addr = 32'hA0 + 32'h20 * $urandom_range(0, 1); cfg_ctrl = 2'($urandom_range(0, 3));
        if (cfg_sel) cfg_addr = 32'h300 + 32'h100 * $urandom_range(0, 1);
      end
      step();
      cfg_we = 0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule